// File: doc/BRIEF.md
# Segmented Address Translation Front-End

This block is the first stage that a 32-bit virtual address passes through on its way to a physical address. It takes one access request at a time and settles it in one of two ways. It can resolve the request directly, with a result one cycle later. Otherwise it hands the request to a downstream page translator and forwards that translator's answer. The request carries the virtual address, the access kind (read, write or execute) and a user-mode flag.

A direct resolution happens in two cases. The first is when address translation is switched off in the global configuration word. The address then passes through unchanged with every permission granted. The second is when a kernel-mode access falls into a segment that the segment mask marks as direct-mapped. The top four address bits name one of sixteen segments. For such a segment, those four bits are replaced by a base nibble taken from one of two packed kernel-base words.

Every other access goes to the page path over a valid/ready request and a single-cycle response. A select line tells the page path whether the instruction translator (for execute accesses) or the data translator (for reads and writes) should handle it. The same indication comes back with every result.

Top module: `seg_xlate_front`

## Requirements
- R1: After reset, `out_valid` and `pg_req_valid` are 0 and `req_ready` is 1.
- R2: When `glob_cfg` bits 2 and 3 are both 0, an accepted request produces `out_valid`=1 on the next cycle with `out_paddr` equal to the virtual address, `out_perm`=3'b111 (bit 2 execute, bit 1 write, bit 0 read) and `out_miss`=0. No page request is issued.
- R3: Translation counts as on when `glob_cfg` bit 2 or bit 3 is 1; all other `glob_cfg` bits have no effect on routing or results.
- R4: With translation on, a request with `req_user`=0 whose segment (`req_vaddr[31:28]`) has its bit set in `seg_mask` is answered on the next cycle with `out_paddr`={base, `req_vaddr[27:0]`}, `out_perm`=3'b111 and `out_miss`=0.
- R5: The base nibble for segment s is `kbase_lo[4s+3:4s]` for s in 0..7 and `kbase_hi[4(s-8)+3:4(s-8)]` for s in 8..15.
- R6: With translation on, a user-mode request always goes to the page path, whatever `seg_mask` holds.
- R7: A request for the page path raises `pg_req_valid` on the cycle after acceptance, with the virtual address, kind and user flag. `pg_req_valid` and these fields stay steady until a cycle with `pg_req_ready`=1.
- R8: `pg_req_insn` and `out_insn` are 1 exactly when the kind is execute (`req_kind`=2'b10). Kinds 2'b00 (read), 2'b01 (write) and 2'b11 select the data translator.
- R9: After the page request is taken, the cycle after `pg_resp_valid`=1 shows `out_valid`=1 with `out_paddr`, `out_perm` and `out_miss` copied from the response.
- R10: From acceptance of a page-path request until its result appears, `req_ready` is 0 and `req_valid` is ignored.
- R11: Each accepted request yields exactly one cycle of `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 execute |
| req_user | input | 1 | Access is in user mode |
| glob_cfg | input | 32 | Global configuration word (bits 2,3 enable) |
| seg_mask | input | 16 | Direct-mapped segment mask |
| kbase_lo | input | 32 | Base nibbles for segments 0..7 |
| kbase_hi | input | 32 | Base nibbles for segments 8..15 |
| pg_req_valid | output | 1 | Page-path request valid |
| pg_req_ready | input | 1 | Page path takes the request |
| pg_req_vaddr | output | 32 | Address to the page path |
| pg_req_kind | output | 2 | Access kind to the page path |
| pg_req_user | output | 1 | User flag to the page path |
| pg_req_insn | output | 1 | 1 selects instruction translator |
| pg_resp_valid | input | 1 | Page-path result valid |
| pg_resp_paddr | input | 32 | Page-path physical address |
| pg_resp_perm | input | 3 | Page-path permissions {x,w,r} |
| pg_resp_miss | input | 1 | Page-path miss |
| out_valid | output | 1 | Result valid |
| out_paddr | output | 32 | Physical address |
| out_perm | output | 3 | Permissions {x,w,r} |
| out_miss | output | 1 | Translation missed |
| out_insn | output | 1 | Result came from instruction-side routing |

## Verification
The assertions assume that the page path returns exactly one response per request it takes, and only after taking it. They also assume that `pg_resp_valid` never rises while the block is idle or still offering the request. The bench's page-path model keeps to this: it raises the response only after it has driven `pg_req_ready` for one cycle, and only once. Configuration, mask and base words are changed only between requests. Stray `req_valid` pulses are driven only while a page transaction is outstanding, to exercise the ignore rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_SPARE = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam perm_t PERM_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};
    localparam perm_t PERM_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } fsm_e;

    function automatic logic is_exec(input logic [1:0] kind);
        return kind == ACC_EXEC;
    endfunction

endpackage

// File: rtl/seg_base_sel.sv
module seg_base_sel #(
    parameter int SEG_BITS = 4,
    parameter int REG_W    = 32
) (
    input  logic [SEG_BITS-1:0] seg,
    input  logic [REG_W-1:0]    kbase_lo,
    input  logic [REG_W-1:0]    kbase_hi,
    output logic [SEG_BITS-1:0] base
);
    localparam int NUM_SEG = 2 ** SEG_BITS;
    localparam int PER_REG = REG_W / SEG_BITS;

    logic [SEG_BITS-1:0] nib [NUM_SEG];

    // Lower half of the segments comes from the low word, upper half from the high word.
    for (genvar g = 0; g < PER_REG; g++) begin : g_nib
        assign nib[g]           = kbase_lo[g*SEG_BITS +: SEG_BITS];
        assign nib[g + PER_REG] = kbase_hi[g*SEG_BITS +: SEG_BITS];
    end

    assign base = nib[seg];

endmodule

// File: rtl/seg_route_decode.sv
module seg_route_decode
    import seg_xlate_pkg::*;
#(
    parameter int          SEG_BITS = 4,
    parameter int          CFG_W    = 32,
    parameter logic [31:0] EN_BITS  = 32'h0000_000C
) (
    input  logic [CFG_W-1:0]       glob_cfg,
    input  logic [2**SEG_BITS-1:0] seg_mask,
    input  logic [SEG_BITS-1:0]    seg,
    input  logic                   user,
    input  logic [1:0]             kind,
    output logic                   mmu_on,
    output logic                   seg_direct,
    output logic                   bypass,
    output logic                   use_insn
);
    localparam logic [CFG_W-1:0] EN_MASK = EN_BITS[CFG_W-1:0];

    always_comb begin
        mmu_on     = |(glob_cfg & EN_MASK);
        seg_direct = mmu_on && !user && seg_mask[seg];
        bypass     = !mmu_on || seg_direct;
        use_insn   = is_exec(kind);
    end

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
    import seg_xlate_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int SEG_BITS = 4,
    parameter int CFG_W    = 32,
    parameter int KREG_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_kind,
    input  logic                   req_user,
    input  logic [CFG_W-1:0]       glob_cfg,
    input  logic [2**SEG_BITS-1:0] seg_mask,
    input  logic [KREG_W-1:0]      kbase_lo,
    input  logic [KREG_W-1:0]      kbase_hi,
    output logic                   pg_req_valid,
    input  logic                   pg_req_ready,
    output logic [VA_W-1:0]        pg_req_vaddr,
    output logic [1:0]             pg_req_kind,
    output logic                   pg_req_user,
    output logic                   pg_req_insn,
    input  logic                   pg_resp_valid,
    input  logic [VA_W-1:0]        pg_resp_paddr,
    input  logic [2:0]             pg_resp_perm,
    input  logic                   pg_resp_miss,
    output logic                   out_valid,
    output logic [VA_W-1:0]        out_paddr,
    output logic [2:0]             out_perm,
    output logic                   out_miss,
    output logic                   out_insn
);
    localparam int OFF_W = VA_W - SEG_BITS;

    typedef struct packed {
        fsm_e            st;
        logic [VA_W-1:0] va;
        logic [1:0]      kind;
        logic            user;
        logic            insn;
        logic            o_vld;
        logic [VA_W-1:0] o_pa;
        perm_t           o_perm;
        logic            o_miss;
        logic            o_insn;
    } state_t;

    state_t s_d, s_q;

    logic [SEG_BITS-1:0] seg_w;
    logic [SEG_BITS-1:0] base_w;
    logic                mmu_on_w, seg_direct_w, bypass_w, use_insn_w;

    assign seg_w = req_vaddr[VA_W-1 -: SEG_BITS];

    seg_base_sel #(
        .SEG_BITS (SEG_BITS),
        .REG_W    (KREG_W)
    ) u_base (
        .seg      (seg_w),
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .base     (base_w)
    );

    seg_route_decode #(
        .SEG_BITS (SEG_BITS),
        .CFG_W    (CFG_W)
    ) u_route (
        .glob_cfg   (glob_cfg),
        .seg_mask   (seg_mask),
        .seg        (seg_w),
        .user       (req_user),
        .kind       (req_kind),
        .mmu_on     (mmu_on_w),
        .seg_direct (seg_direct_w),
        .bypass     (bypass_w),
        .use_insn   (use_insn_w)
    );

    always_comb begin
        s_d       = s_q;
        s_d.o_vld = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (bypass_w) begin
                        s_d.o_vld  = 1'b1;
                        s_d.o_pa   = seg_direct_w ? {base_w, req_vaddr[OFF_W-1:0]} : req_vaddr;
                        s_d.o_perm = PERM_ALL;
                        s_d.o_miss = 1'b0;
                        s_d.o_insn = use_insn_w;
                    end else begin
                        s_d.st   = ST_ISSUE;
                        s_d.va   = req_vaddr;
                        s_d.kind = req_kind;
                        s_d.user = req_user;
                        s_d.insn = use_insn_w;
                    end
                end
            end
            ST_ISSUE: begin
                if (pg_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (pg_resp_valid) begin
                    s_d.st     = ST_IDLE;
                    s_d.o_vld  = 1'b1;
                    s_d.o_pa   = pg_resp_paddr;
                    s_d.o_perm = perm_t'(pg_resp_perm);
                    s_d.o_miss = pg_resp_miss;
                    s_d.o_insn = s_q.insn;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.o_perm <= PERM_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready    = (s_q.st == ST_IDLE);
    assign pg_req_valid = (s_q.st == ST_ISSUE);
    assign pg_req_vaddr = s_q.va;
    assign pg_req_kind  = s_q.kind;
    assign pg_req_user  = s_q.user;
    assign pg_req_insn  = s_q.insn;
    assign out_valid    = s_q.o_vld;
    assign out_paddr    = s_q.o_pa;
    assign out_perm     = s_q.o_perm;
    assign out_miss     = s_q.o_miss;
    assign out_insn     = s_q.o_insn;

endmodule

// File: rtl/seg_xlate_front_chk.sv
module seg_xlate_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        req_user,
    input logic [31:0] glob_cfg,
    input logic [15:0] seg_mask,
    input logic        pg_req_valid,
    input logic        pg_req_ready,
    input logic [31:0] pg_req_vaddr,
    input logic [1:0]  pg_req_kind,
    input logic        pg_req_insn,
    input logic        pg_resp_valid,
    input logic [31:0] pg_resp_paddr,
    input logic        out_valid,
    input logic [31:0] out_paddr,
    input logic [2:0]  out_perm,
    input logic        out_miss
);
    logic on_c, take_c;
    assign on_c   = glob_cfg[2] | glob_cfg[3];
    assign take_c = req_valid && req_ready;

    p_direct_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_c && !on_c |=> out_valid && out_paddr == $past(req_vaddr)
                            && out_perm == 3'b111 && !out_miss && !pg_req_valid);

    p_seg_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_c && on_c && !req_user && seg_mask[req_vaddr[31:28]]
            |=> out_valid && out_paddr[27:0] == $past(req_vaddr[27:0])
                && out_perm == 3'b111 && !out_miss);

    p_user_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_c && on_c && req_user |=> pg_req_valid && !out_valid
                                       && pg_req_vaddr == $past(req_vaddr));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req_valid && !pg_req_ready |=> pg_req_valid && $stable(pg_req_vaddr)
                                          && $stable(pg_req_kind));

    p_insn_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req_valid |-> pg_req_insn == (pg_req_kind == 2'b10));

    p_resp_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && !pg_req_valid && pg_resp_valid
            |=> out_valid && out_paddr == $past(pg_resp_paddr) && req_ready);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req_valid |-> !req_ready && !out_valid);

endmodule

bind seg_xlate_front seg_xlate_front_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .req_user      (req_user),
    .glob_cfg      (glob_cfg),
    .seg_mask      (seg_mask),
    .pg_req_valid  (pg_req_valid),
    .pg_req_ready  (pg_req_ready),
    .pg_req_vaddr  (pg_req_vaddr),
    .pg_req_kind   (pg_req_kind),
    .pg_req_insn   (pg_req_insn),
    .pg_resp_valid (pg_resp_valid),
    .pg_resp_paddr (pg_resp_paddr),
    .out_valid     (out_valid),
    .out_paddr     (out_paddr),
    .out_perm      (out_perm),
    .out_miss      (out_miss)
);

// File: tb/seg_xlate_front_test.sv
module seg_xlate_front_test;

    localparam logic [31:0] KLO = 32'h9E3F_51C7;
    localparam logic [31:0] KHI = 32'h28B6_D04A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] glob_cfg = '0;
    logic [15:0] seg_mask = '0;
    logic        pg_req_valid;
    logic        pg_req_ready = 1'b0;
    logic [31:0] pg_req_vaddr;
    logic [1:0]  pg_req_kind;
    logic        pg_req_user;
    logic        pg_req_insn;
    logic        pg_resp_valid = 1'b0;
    logic [31:0] pg_resp_paddr = '0;
    logic [2:0]  pg_resp_perm = '0;
    logic        pg_resp_miss = 1'b0;
    logic        out_valid;
    logic [31:0] out_paddr;
    logic [2:0]  out_perm;
    logic        out_miss;
    logic        out_insn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_xlate_front uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user),
        .glob_cfg(glob_cfg), .seg_mask(seg_mask), .kbase_lo(KLO), .kbase_hi(KHI),
        .pg_req_valid(pg_req_valid), .pg_req_ready(pg_req_ready),
        .pg_req_vaddr(pg_req_vaddr), .pg_req_kind(pg_req_kind),
        .pg_req_user(pg_req_user), .pg_req_insn(pg_req_insn),
        .pg_resp_valid(pg_resp_valid), .pg_resp_paddr(pg_resp_paddr),
        .pg_resp_perm(pg_resp_perm), .pg_resp_miss(pg_resp_miss),
        .out_valid(out_valid), .out_paddr(out_paddr), .out_perm(out_perm),
        .out_miss(out_miss), .out_insn(out_insn)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                           input logic [31:0] cfg, input logic [15:0] mask,
                           input int drdy, input int dresp);
        int s;
        logic en, direct, insn;
        logic [3:0] nib;
        logic [31:0] exp_pa, rpa;
        logic [2:0] rperm;
        logic rmiss;
        s      = int'(va[31:28]);
        en     = cfg[2] | cfg[3];
        direct = !en || (!usr && mask[s]);
        insn   = (kind == 2'b10);
        nib    = (s < 8) ? KLO[(s % 8) * 4 +: 4] : KHI[(s % 8) * 4 +: 4];
        exp_pa = en ? {nib, va[27:0]} : va;
        rpa    = va ^ 32'h3C3C_1234;
        rperm  = {kind == 2'b10, kind == 2'b01, 1'b1};
        rmiss  = va[13] ^ usr;

        @(negedge clk);
        glob_cfg = cfg; seg_mask = mask;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 route", {31'd0, pg_req_valid}, {31'd0, !direct});
        if (direct) begin
            check(en ? "R4 valid" : "R2 valid", {31'd0, out_valid}, 32'd1);
            check(en ? "R4 paddr" : "R2 paddr", out_paddr, exp_pa);
            if (en) check("R5 base", {28'd0, out_paddr[31:28]}, {28'd0, nib});
            check("R2 perm", {29'd0, out_perm}, 32'd7);
            check("R4 miss", {31'd0, out_miss}, 32'd0);
            check("R8 out_insn", {31'd0, out_insn}, {31'd0, insn});
        end else begin
            if (usr) check("R6 user to page", {31'd0, pg_req_valid}, 32'd1);
            check("R7 vaddr", pg_req_vaddr, va);
            check("R7 kind", {30'd0, pg_req_kind}, {30'd0, kind});
            check("R7 user", {31'd0, pg_req_user}, {31'd0, usr});
            check("R8 pg_insn", {31'd0, pg_req_insn}, {31'd0, insn});
            check("R10 busy", {31'd0, req_ready}, 32'd0);
            req_valid = 1'b1; req_vaddr = ~va; req_kind = 2'b00; req_user = 1'b0;
            for (int k = 0; k < drdy; k++) begin
                @(negedge clk);
                check("R7 hold", {31'd0, pg_req_valid}, 32'd1);
                check("R7 stable", pg_req_vaddr, va);
            end
            pg_req_ready = 1'b1;
            @(negedge clk);
            pg_req_ready = 1'b0;
            check("R7 taken", {31'd0, pg_req_valid}, 32'd0);
            check("R10 busy wait", {31'd0, req_ready}, 32'd0);
            for (int k = 0; k < dresp; k++) begin
                @(negedge clk);
                check("R11 no early out", {31'd0, out_valid}, 32'd0);
            end
            pg_resp_valid = 1'b1; pg_resp_paddr = rpa; pg_resp_perm = rperm; pg_resp_miss = rmiss;
            @(negedge clk);
            pg_resp_valid = 1'b0; req_valid = 1'b0;
            check("R9 valid", {31'd0, out_valid}, 32'd1);
            check("R9 paddr", out_paddr, rpa);
            check("R9 perm", {29'd0, out_perm}, {29'd0, rperm});
            check("R9 miss", {31'd0, out_miss}, {31'd0, rmiss});
            check("R8 out_insn page", {31'd0, out_insn}, {31'd0, insn});
        end
        @(negedge clk);
        check("R11 single pulse", {31'd0, out_valid}, 32'd0);
        check("R10 ignored req", {31'd0, pg_req_valid}, 32'd0);
        check("R10 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        int idx;
        logic [15:0] mask;
        logic [31:0] cfg, va;
        idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 pg_req_valid", {31'd0, pg_req_valid}, 32'd0);
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        for (int m = 0; m < 2; m++) begin
            mask = (m == 0) ? 16'hA5C3 : 16'h5A3C;
            for (int e = 0; e < 4; e++) begin
                cfg = 32'hFFFF_FFF3 & ~32'h0000_0020;
                cfg[2] = e[0]; cfg[3] = e[1];
                for (int u = 0; u < 2; u++) begin
                    for (int s = 0; s < 16; s++) begin
                        for (int k = 0; k < 4; k++) begin
                            va = {s[3:0], 28'(idx * 32'h0123_4567 + 32'h000A_5F00)};
                            run_one(va, k[1:0], u[0], cfg, mask, idx % 3, idx % 4);
                            idx++;
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule